// File: doc/BRIEF.md
# Stack-Top Integer Shift Unit

This unit executes the two integer shift instructions of a 32-bit stack machine on a small private stack. On a start strobe it checks the opcode byte. If the opcode is one of the two shift codes, it takes the top stack word as the shift amount and the word beneath it as the value. It shifts that value left with zero fill or right with sign fill, writes the result back, and ends with a one-cycle done pulse. The stack shrinks by one entry: two words are consumed and one result word is left.

Words enter the stack through a valid/ready push port. A word moves on a cycle in which both `push_valid` and `push_ready` are high. `push_ready` drops while the stack is full, while an instruction is in flight, and in any idle cycle where `start` is also high. A producer that sees `push_ready` low keeps `push_valid` and `push_data` steady and waits. The top word and the current depth are visible at all times. An unknown opcode raises an opcode-error flag. A shift with fewer than two stacked words raises an underflow flag. In both error cases the stack is left untouched.

Top module: `stk_shift_unit`

## Requirements
- R1: After reset the depth is 0, `done` and both error flags are low, and `push_ready` is high.
- R2: A push transfers when `push_valid` and `push_ready` are both high. It raises the depth by one and makes `tos_data` equal the pushed word. `push_ready` is low while the depth equals the stack capacity of 16.
- R3: Opcode 8'h78 shifts the value left by the shift amount and fills the vacated low bits with zeros.
- R4: Opcode 8'h7A shifts the value right by the shift amount and copies bit 31 into every vacated high bit.
- R5: The shift amount is bits [4:0] of the top word, giving 0 to 31. Bits [31:5] of that word have no effect on the result.
- R6: A shift lowers the depth by exactly one. The result is written into the slot that held the value, so it becomes the new `tos_data`.
- R7: `start` is sampled on a clock edge. For a shift it is accepted at that edge, and `done` is high for exactly one cycle, two clock edges after the accepting edge.
- R8: A shift opcode started with fewer than two stacked words raises `err_underflow` together with `done` one edge after the accepting edge. Depth and stack contents are left unchanged.
- R9: Any opcode other than 8'h78 and 8'h7A raises `err_opcode` together with `done` one edge after the accepting edge. The stack is left unchanged. The opcode check is made before the depth check.
- R10: `start` is ignored while an instruction is in flight, including during the done cycle.
- R11: When `start` and `push_valid` are high in the same idle cycle, the instruction is accepted, the push is held off, and the push transfers only after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction with `opcode` |
| opcode | input | 8 | Instruction code byte |
| push_valid | input | 1 | Push word offered |
| push_ready | output | 1 | Push word can be taken this cycle |
| push_data | input | 32 | Word to push |
| done | output | 1 | One-cycle completion pulse |
| err_opcode | output | 1 | Unknown opcode, valid with `done` |
| err_underflow | output | 1 | Fewer than two words, valid with `done` |
| depth | output | 5 | Number of stacked words |
| tos_data | output | 32 | Top stack word, zero when empty |

## Verification
The two functions that can collide are a push and the start of an instruction in the same idle cycle. The bench raises `start` and `push_valid` on the same falling edge. It judges the collision at the ports: `push_ready` must already be low in that cycle, and the shift result and depth must appear with `done` exactly as if no push had been offered. The held word must land on top only after `done`, leaving the depth one above the post-shift value. The bench also drives a second, illegal `start` while a shift is in flight and checks that no opcode error appears.

// File: rtl/stk_shift_pkg.sv
`timescale 1ns/1ps
package stk_shift_pkg;
  localparam logic [7:0] OPC_SHL = 8'h78;
  localparam logic [7:0] OPC_SAR = 8'h7A;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_DONE
  } st_e;

  typedef enum logic {
    SH_LEFT,
    SH_ARITH_RIGHT
  } dir_e;
endpackage

// File: rtl/stk_shift_barrel.sv
`timescale 1ns/1ps
module stk_shift_barrel
  import stk_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  amount,
  input  dir_e              dir,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] stage [CNT_W+1];

  assign stage[0] = operand;

  // one stage per amount bit, each moving by a power of two
  for (genvar g = 0; g < CNT_W; g++) begin : g_stage
    localparam int SH = 1 << g;
    logic [DATA_W-1:0] moved_l;
    logic [DATA_W-1:0] moved_r;
    assign moved_l = {stage[g][DATA_W-1-SH:0], {SH{1'b0}}};
    assign moved_r = {{SH{stage[g][DATA_W-1]}}, stage[g][DATA_W-1:SH]};
    assign stage[g+1] = !amount[g]        ? stage[g] :
                        (dir == SH_LEFT)  ? moved_l  : moved_r;
  end

  assign result = stage[CNT_W];
endmodule

// File: rtl/stk_shift_store.sv
`timescale 1ns/1ps
module stk_shift_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_word,
  input  logic              commit_en,
  input  logic [DATA_W-1:0] commit_word,
  output logic [PTR_W-1:0]  level,
  output logic              full,
  output logic [DATA_W-1:0] top_word,
  output logic [DATA_W-1:0] next_word
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  sp;
  logic [ADDR_W-1:0] free_idx, top_idx, next_idx;

  assign free_idx = ADDR_W'(sp);
  assign top_idx  = ADDR_W'(sp - PTR_W'(1));
  assign next_idx = ADDR_W'(sp - PTR_W'(2));

  always_ff @(posedge clk) begin
    if (push_en) begin
      slots[free_idx] <= push_word;
    end else if (commit_en) begin
      slots[next_idx] <= commit_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
    end else if (push_en) begin
      sp <= sp + PTR_W'(1);
    end else if (commit_en) begin
      sp <= sp - PTR_W'(1);
    end
  end

  assign level     = sp;
  assign full      = (sp == PTR_W'(DEPTH));
  assign top_word  = (sp >= PTR_W'(1)) ? slots[top_idx]  : '0;
  assign next_word = (sp >= PTR_W'(2)) ? slots[next_idx] : '0;

  // R2
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !full);

  // R6
  commit_pops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> (sp == $past(sp) - PTR_W'(1)));

  // R11
  push_commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_en && commit_en));
endmodule

// File: rtl/stk_shift_ctrl.sv
`timescale 1ns/1ps
module stk_shift_ctrl
  import stk_shift_pkg::*;
#(
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [PTR_W-1:0] level,
  output logic             load_ops,
  output logic             commit,
  output logic             idle,
  output logic             done,
  output dir_e             dir,
  output logic             err_opc,
  output logic             err_uflow
);
  st_e  state;
  logic legal;
  logic shallow;

  assign legal   = (opcode == OPC_SHL) || (opcode == OPC_SAR);
  assign shallow = (level < PTR_W'(2));

  assign idle     = (state == ST_IDLE);
  assign load_ops = idle && start && legal && !shallow;
  assign commit   = (state == ST_EXEC);
  assign done     = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dir       <= SH_LEFT;
      err_opc   <= 1'b0;
      err_uflow <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (!legal) begin
              err_opc <= 1'b1;
              state   <= ST_DONE;
            end else if (shallow) begin
              err_uflow <= 1'b1;
              state     <= ST_DONE;
            end else begin
              dir   <= (opcode == OPC_SAR) ? SH_ARITH_RIGHT : SH_LEFT;
              state <= ST_EXEC;
            end
          end
        end
        ST_EXEC: state <= ST_DONE;
        default: begin
          state     <= ST_IDLE;
          err_opc   <= 1'b0;
          err_uflow <= 1'b0;
        end
      endcase
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  exec_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ops |=> ##1 done);

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_opc && err_uflow));

  // R10
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && start) |=> (done && !err_opc && !err_uflow));
endmodule

// File: rtl/stk_shift_unit.sv
`timescale 1ns/1ps
module stk_shift_unit
  import stk_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  output logic              done,
  output logic              err_opcode,
  output logic              err_underflow,
  output logic [PTR_W-1:0]  depth,
  output logic [DATA_W-1:0] tos_data
);
  localparam int CNT_W = $clog2(DATA_W);

  logic              load_ops, commit, idle, full;
  dir_e              dir;
  logic [DATA_W-1:0] top_word, next_word, shifted;
  logic [DATA_W-1:0] value_q;
  logic [CNT_W-1:0]  amount_q;

  stk_shift_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .opcode    (opcode),
    .level     (depth),
    .load_ops  (load_ops),
    .commit    (commit),
    .idle      (idle),
    .done      (done),
    .dir       (dir),
    .err_opc   (err_opcode),
    .err_uflow (err_underflow)
  );

  // operands are latched when the shift is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q  <= '0;
      amount_q <= '0;
    end else if (load_ops) begin
      value_q  <= next_word;
      amount_q <= top_word[CNT_W-1:0];
    end
  end

  stk_shift_barrel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_barrel (
    .operand (value_q),
    .amount  (amount_q),
    .dir     (dir),
    .result  (shifted)
  );

  assign push_ready = idle && !start && !full;

  stk_shift_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_en     (push_valid && push_ready),
    .push_word   (push_data),
    .commit_en   (commit),
    .commit_word (shifted),
    .level       (depth),
    .full        (full),
    .top_word    (top_word),
    .next_word   (next_word)
  );

  assign tos_data = top_word;

  // R8
  uflow_keeps_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |-> (depth == $past(depth)));

  // R9
  opc_keeps_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_opcode |-> (depth == $past(depth)));

  // R4
  sar_sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && dir == SH_ARITH_RIGHT && amount_q != '0)
      |-> (shifted[DATA_W-1] == value_q[DATA_W-1]));

  // R3
  shl_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && dir == SH_LEFT && amount_q != '0) |-> !shifted[0]);

  // R6
  result_on_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (tos_data == $past(shifted)));
endmodule

// File: tb/stk_shift_unit_bench.sv
`timescale 1ns/1ps
module stk_shift_unit_bench;
  localparam int DW = 32;
  localparam int DP = 16;
  localparam int PW = $clog2(DP + 1);
  localparam int NV = 8;

  // {opcode, value, amount word}
  localparam logic [71:0] VEC [NV] = '{
    {8'h78, 32'h0000_0001, 32'h0000_0000},
    {8'h78, 32'h0000_0001, 32'h0000_001F},
    {8'h7A, 32'h8000_0000, 32'h0000_001F},
    {8'h7A, 32'h8000_0000, 32'h0000_0000},
    {8'h7A, 32'h7FFF_FFFF, 32'h0000_0001},
    {8'h78, 32'hDEAD_BEEF, 32'hFFFF_FFE4},
    {8'h7A, 32'hF000_0000, 32'h0000_0104},
    {8'h7A, 32'h1234_5678, 32'h0000_0023}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    opcode = 8'h00;
  logic          push_valid = 1'b0;
  logic          push_ready;
  logic [DW-1:0] push_data = '0;
  logic          done, err_opcode, err_underflow;
  logic [PW-1:0] depth;
  logic [DW-1:0] tos_data;

  int nchk = 0;
  int nfail = 0;
  logic [DW-1:0] mdl [DP];
  int mdepth = 0;

  always #2.5 clk = ~clk;

  stk_shift_unit #(.DATA_W(DW), .DEPTH(DP)) u_stk_shift_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .done(done), .err_opcode(err_opcode), .err_underflow(err_underflow),
    .depth(depth), .tos_data(tos_data)
  );

  function automatic logic [DW-1:0] expect_shift(input logic [7:0] opc,
      input logic [DW-1:0] v, input logic [DW-1:0] amt);
    logic [DW-1:0] r = v;
    for (int i = 0; i < int'(amt[4:0]); i++)
      r = (opc == 8'h7A) ? {r[DW-1], r[DW-1:1]} : {r[DW-2:0], 1'b0};
    return r;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  task automatic push_word(input logic [DW-1:0] w);
    push_valid = 1'b1;
    push_data  = w;
    #1;
    while (!push_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    push_valid = 1'b0;
    mdl[mdepth] = w;
    mdepth++;
  endtask

  task automatic run_shift(input logic [7:0] opc, input string tag);
    logic [DW-1:0] exp;
    exp = expect_shift(opc, mdl[mdepth-2], mdl[mdepth-1]);
    start  = 1'b1;
    opcode = opc;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R7 no early done"}, 32'(done), 32'd0);
    @(negedge clk);
    chk({tag, " R7 done"}, 32'(done), 32'd1);
    chk({tag, " R9/R8 flags clear"}, {30'd0, err_opcode, err_underflow}, 32'd0);
    mdepth--;
    mdl[mdepth-1] = exp;
    chk({tag, " R3/R4/R5 result"}, tos_data, exp);
    chk({tag, " R6 depth"}, 32'(depth), 32'(mdepth));
    @(negedge clk);
    chk({tag, " R7 single pulse"}, 32'(done), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 depth", 32'(depth), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 flags", {30'd0, err_opcode, err_underflow}, 32'd0);
    chk("R1 push_ready", 32'(push_ready), 32'd1);

    // underflow with empty stack
    start = 1'b1; opcode = 8'h78;
    @(negedge clk);
    start = 1'b0;
    chk("R8 done", 32'(done), 32'd1);
    chk("R8 flag empty", 32'(err_underflow), 32'd1);
    chk("R8 depth empty", 32'(depth), 32'd0);
    @(negedge clk);

    push_word(32'h0000_0005);
    chk("R2 push depth", 32'(depth), 32'd1);
    chk("R2 push tos", tos_data, 32'h5);

    // underflow with one word
    start = 1'b1; opcode = 8'h7A;
    @(negedge clk);
    start = 1'b0;
    chk("R8 flag one word", 32'(err_underflow), 32'd1);
    chk("R8 depth one word", 32'(depth), 32'd1);
    chk("R8 tos one word", tos_data, 32'h5);
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      push_word(VEC[v][63:32]);
      push_word(VEC[v][31:0]);
      run_shift(VEC[v][71:64], $sformatf("vec%0d", v));
    end

    // unknown opcode with enough words
    push_word(32'h0000_0003);
    start = 1'b1; opcode = 8'h79;
    @(negedge clk);
    start = 1'b0;
    chk("R9 flag", 32'(err_opcode), 32'd1);
    chk("R9 no underflow", 32'(err_underflow), 32'd0);
    chk("R9 depth", 32'(depth), 32'(mdepth));
    chk("R9 tos", tos_data, 32'h3);
    @(negedge clk);

    // R10: second start during a shift is ignored
    begin
      logic [DW-1:0] exp10;
      exp10 = expect_shift(8'h7A, mdl[mdepth-2], mdl[mdepth-1]);
      start = 1'b1; opcode = 8'h7A;
      @(negedge clk);
      opcode = 8'h00;
      @(negedge clk);
      mdepth--;
      mdl[mdepth-1] = exp10;
      chk("R10 done", 32'(done), 32'd1);
      chk("R10 no opcode error", 32'(err_opcode), 32'd0);
      chk("R10 result", tos_data, exp10);
      @(negedge clk);
      start = 1'b0;
      #1;
      chk("R10 no extra done", 32'(done), 32'd0);
      @(negedge clk);
      chk("R10 still quiet", {30'd0, done, err_opcode}, 32'd0);
      chk("R10 depth", 32'(depth), 32'(mdepth));
    end

    // R11: push and start in the same idle cycle
    push_word(32'h0000_0002);
    begin
      logic [DW-1:0] exp11;
      exp11 = expect_shift(8'h78, mdl[mdepth-2], mdl[mdepth-1]);
      push_valid = 1'b1; push_data = 32'h0000_0077;
      start = 1'b1; opcode = 8'h78;
      #1;
      chk("R11 push held", 32'(push_ready), 32'd0);
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      mdepth--;
      mdl[mdepth-1] = exp11;
      chk("R11 done", 32'(done), 32'd1);
      chk("R11 result", tos_data, exp11);
      chk("R11 depth at done", 32'(depth), 32'(mdepth));
      @(negedge clk);
      @(negedge clk);
      push_valid = 1'b0;
      mdl[mdepth] = 32'h77;
      mdepth++;
      chk("R11 late push depth", 32'(depth), 32'(mdepth));
      chk("R11 late push tos", tos_data, 32'h77);
    end

    // R2: fill to capacity
    while (mdepth < DP) push_word(32'h1000_0000 + 32'(mdepth));
    #1;
    chk("R2 full depth", 32'(depth), 32'(DP));
    chk("R2 full not ready", 32'(push_ready), 32'd0);
    push_valid = 1'b1; push_data = 32'hBAD0_0000;
    @(negedge clk);
    @(negedge clk);
    push_valid = 1'b0;
    chk("R2 full holds depth", 32'(depth), 32'(DP));
    chk("R2 full holds tos", tos_data, mdl[DP-1]);

    summary();
    $finish;
  end
endmodule